// File: doc/BRIEF.md
# Quiet Floating-Point Comparator

This block compares two IEEE-754 binary floating-point operands, in single or double precision, and answers one predicate chosen per use: equal, greater-than or greater-or-equal. It has no clock. It produces an 8-bit predicate value that is all ones when the predicate holds and all zeros when it does not. It also drives a five-bit exception-flag vector that a surrounding core merges into its sticky status register.

Each compare is quiet. An operand that is a NaN, quiet or signalling, makes every predicate false and raises no flag. No other compare raises a flag either, so the flag vector stays zero. The ordering follows the usual numeric rules: the two zeros are equal, infinities sit beyond every finite value, and finite values are ordered by sign and magnitude.

Top module: `quietFpCompare`

## Requirements
- R1: `predSel` chooses the predicate: 0 = equal, 1 = greater-than (A > B), 2 = greater-or-equal (A >= B).
- R2: `predSel` = 3 is reserved and always yields a false predicate.
- R3: `precSel` = 0 compares the low 32 bits of each operand as single precision (sign bit 31, exponent bits 30:23, fraction bits 22:0), and the upper 32 bits have no effect. `precSel` = 1 compares all 64 bits as double precision (sign bit 63, exponent bits 62:52, fraction bits 51:0).
- R4: If either operand is a NaN (exponent all ones, fraction non-zero, quiet or signalling), every predicate is false.
- R5: `flagsOut` is zero for every compare, NaN inputs included. Index 0 is invalid, 1 is divide-by-zero, 2 is overflow, 3 is underflow and 4 is inexact. These map to status bits 1 to 5.
- R6: +0 and -0 compare as equal, and neither is greater than the other.
- R7: +inf is greater than every finite value and -inf. -inf is less than every finite value. An infinity equals an infinity of the same sign.
- R8: A positive finite operand is greater than any negative finite operand. Two positive operands are ordered by their magnitude bits.
- R9: When both operands are negative, the larger magnitude is the smaller value.
- R10: `predOut` is 8'hFF when the predicate holds and 8'h00 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| precSel | input | 1 | 0 = single precision on the low 32 bits, 1 = double precision |
| predSel | input | 2 | Predicate code: 0 equal, 1 greater, 2 greater-or-equal, 3 reserved |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| predOut | output | 8 | Predicate result, all ones or all zeros |
| flagsOut | output | 5 | Exception flags (invalid, div-by-zero, overflow, underflow, inexact), always zero |

## Verification
The bench targets signalling NaNs, whose top fraction bit is clear. A detector that only tests the quiet bit would let such an operand through and could report a true greater-than. It pairs +0 with -0 because a raw bit compare calls them unequal and orders -0 above +0. It uses two negative operands, where a missing inversion reverses greater-than. In single precision it fills the upper operand halves with random bits, so a design that reads those bits gives results that depend on them. Every vector also checks that the flag vector stays zero, which catches a design that raises invalid on a NaN compare.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int DP_EXP_W = 11;
  localparam int DP_MAN_W = 52;
  localparam int OPER_W   = 1 + DP_EXP_W + DP_MAN_W;
  localparam int PRED_W   = 8;
  localparam int FLAG_W   = 5;

  typedef enum logic [1:0] {
    PRED_EQ  = 2'd0,
    PRED_GT  = 2'd1,
    PRED_GE  = 2'd2,
    PRED_RSV = 2'd3
  } predCode_e;

  typedef struct packed {
    logic useDouble;
    logic takeEq;
    logic takeGt;
  } cmpStrobe_t;
endpackage

// File: rtl/fpCmpCtrl.sv
module fpCmpCtrl
  import fpcmp_pkg::*;
(
  input  logic       precSel,
  input  logic [1:0] predSel,
  output cmpStrobe_t strobes
);
  predCode_e code;

  always_comb begin
    code = predCode_e'(predSel);
    strobes.useDouble = precSel;
    strobes.takeEq    = 1'b0;
    strobes.takeGt    = 1'b0;
    unique case (code)
      PRED_EQ:  strobes.takeEq = 1'b1;
      PRED_GT:  strobes.takeGt = 1'b1;
      PRED_GE:  begin
        strobes.takeEq = 1'b1;
        strobes.takeGt = 1'b1;
      end
      PRED_RSV: ;
      default:  ;
    endcase
  end
endmodule

// File: rtl/fpCmpCore.sv
module fpCmpCore #(
  parameter int EXPW = 8,
  parameter int MANW = 23
) (
  input  logic [EXPW+MANW:0] opA,
  input  logic [EXPW+MANW:0] opB,
  output logic               unordered,
  output logic               isEq,
  output logic               isGt
);
  localparam int MAGW = EXPW + MANW;

  logic            signA, signB;
  logic [MAGW-1:0] magA, magB;
  logic            nanA, nanB, bothZero;

  assign signA = opA[MAGW];
  assign signB = opB[MAGW];
  assign magA  = opA[MAGW-1:0];
  assign magB  = opB[MAGW-1:0];

  assign nanA = (&opA[MAGW-1:MANW]) && (|opA[MANW-1:0]);
  assign nanB = (&opB[MAGW-1:MANW]) && (|opB[MANW-1:0]);
  assign unordered = nanA || nanB;
  assign bothZero  = (magA == '0) && (magB == '0);

  always_comb begin
    isEq = 1'b0;
    isGt = 1'b0;
    if (!unordered) begin
      if (bothZero) begin
        isEq = 1'b1;
      end else if (signA != signB) begin
        isGt = !signA;
      end else begin
        isEq = (magA == magB);
        isGt = signA ? (magA < magB) : (magA > magB);
      end
    end
  end

  always_comb begin
    if (isEq && isGt) assert (1'b0) else $error("p_eq_gt_excl_r1: equal and greater at once");
  end
endmodule

// File: rtl/fpCmpDatapath.sv
module fpCmpDatapath
  import fpcmp_pkg::*;
(
  input  cmpStrobe_t        strobes,
  input  logic [OPER_W-1:0] opA,
  input  logic [OPER_W-1:0] opB,
  output logic              unordered,
  output logic              bothZero,
  output logic              result
);
  localparam int SP_W = 1 + SP_EXP_W + SP_MAN_W;

  logic spUnord, spEq, spGt;
  logic dpUnord, dpEq, dpGt;
  logic selEq, selGt;

  fpCmpCore #(.EXPW(SP_EXP_W), .MANW(SP_MAN_W)) u_spCore (
    .opA(opA[SP_W-1:0]), .opB(opB[SP_W-1:0]),
    .unordered(spUnord), .isEq(spEq), .isGt(spGt)
  );

  fpCmpCore #(.EXPW(DP_EXP_W), .MANW(DP_MAN_W)) u_dpCore (
    .opA(opA), .opB(opB),
    .unordered(dpUnord), .isEq(dpEq), .isGt(dpGt)
  );

  always_comb begin
    if (strobes.useDouble) begin
      unordered = dpUnord;
      selEq     = dpEq;
      selGt     = dpGt;
      bothZero  = (opA[OPER_W-2:0] == '0) && (opB[OPER_W-2:0] == '0);
    end else begin
      unordered = spUnord;
      selEq     = spEq;
      selGt     = spGt;
      bothZero  = (opA[SP_W-2:0] == '0) && (opB[SP_W-2:0] == '0);
    end
    result = (strobes.takeEq && selEq) || (strobes.takeGt && selGt);
  end
endmodule

// File: rtl/quietFpCompare.sv
module quietFpCompare
  import fpcmp_pkg::*;
(
  input  logic              precSel,
  input  logic [1:0]        predSel,
  input  logic [OPER_W-1:0] opA,
  input  logic [OPER_W-1:0] opB,
  output logic [PRED_W-1:0] predOut,
  output logic [FLAG_W-1:0] flagsOut
);
  cmpStrobe_t strobes;
  logic       unordered;
  logic       bothZero;
  logic       result;

  fpCmpCtrl u_ctrl (
    .precSel(precSel), .predSel(predSel), .strobes(strobes)
  );

  fpCmpDatapath u_dp (
    .strobes(strobes), .opA(opA), .opB(opB),
    .unordered(unordered), .bothZero(bothZero), .result(result)
  );

  assign predOut  = {PRED_W{result}};
  assign flagsOut = '0;

  always_comb begin
    if (unordered) assert (predOut == '0) else $error("p_nan_false_r4");
    if (predSel == 2'd3) assert (predOut == '0) else $error("p_reserved_false_r2");
    if (bothZero && !unordered && predSel == 2'd0)
      assert (predOut == '1) else $error("p_zero_equal_r6");
    if (bothZero && !unordered && predSel == 2'd1)
      assert (predOut == '0) else $error("p_zero_not_greater_r6");
    assert ((predOut == '0) || (predOut == '1)) else $error("p_pred_form_r10");
  end
endmodule

// File: tb/quietFpCompare_test.sv
module quietFpCompare_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        precSel = 1'b0;
  logic [1:0]  predSel = 2'd0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [7:0]  predOut;
  logic [4:0]  flagsOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quietFpCompare uut (
    .precSel(precSel), .predSel(predSel), .opA(opA), .opB(opB),
    .predOut(predOut), .flagsOut(flagsOut)
  );

  function automatic bit isNanRef(bit dbl, logic [63:0] v);
    if (dbl) return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  function automatic longint keyRef(bit dbl, logic [63:0] v);
    longint m;
    bit s;
    if (dbl) begin m = longint'({1'b0, v[62:0]}); s = v[63]; end
    else     begin m = longint'({33'b0, v[30:0]}); s = v[31]; end
    return s ? -m : m;
  endfunction

  function automatic logic [7:0] refPred(bit dbl, logic [1:0] p, logic [63:0] a, logic [63:0] b);
    longint ka, kb;
    bit r;
    if (isNanRef(dbl, a) || isNanRef(dbl, b)) return 8'h00;
    ka = keyRef(dbl, a);
    kb = keyRef(dbl, b);
    case (p)
      2'd0: r = (ka == kb);
      2'd1: r = (ka > kb);
      2'd2: r = (ka >= kb);
      default: r = 0;
    endcase
    return r ? 8'hFF : 8'h00;
  endfunction

  task automatic checkNow(string tag);
    logic [7:0] exp8;
    exp8 = refPred(precSel, predSel, opA, opB);
    compared++;
    if (predOut !== exp8) begin
      mismatched++;
      $display("FAIL %s predOut: actual=%h expected=%h (prec=%0d pred=%0d a=%h b=%h)",
               tag, predOut, exp8, precSel, predSel, opA, opB);
    end
    compared++;
    if (flagsOut !== 5'b0) begin
      mismatched++;
      $display("FAIL R5 flagsOut: actual=%b expected=00000 (%s)", flagsOut, tag);
    end
  endtask

  task automatic applyVec(bit dbl, logic [1:0] p, logic [63:0] a, logic [63:0] b, string tag);
    @(negedge clk);
    precSel = dbl; predSel = p; opA = a; opB = b;
    @(posedge clk);
    #1;
    checkNow(tag);
  endtask

  task automatic allPreds(bit dbl, logic [63:0] a, logic [63:0] b, string tag);
    for (int p = 0; p < 4; p++) applyVec(dbl, 2'(p), a, b, (p == 3) ? "R2" : tag);
  endtask

  function automatic logic [63:0] makeOp(bit dbl, int kind);
    logic [63:0] v;
    bit s;
    s = $urandom_range(0, 1) == 1;
    v = {$urandom, $urandom};
    if (dbl) begin
      case (kind)
        0: v = {s, 63'b0};
        1: v = {s, 11'h7FF, 52'b0};
        2: v = {s, 11'h7FF, 1'b1, v[50:0]};
        3: v = {s, 11'h7FF, 1'b0, v[50:1], 1'b1};
        4: v = {s, 11'h3FF, 32'h0, v[19:0]};
        default: v[62:52] = 11'(($urandom_range(0, 2045)));
      endcase
    end else begin
      case (kind)
        0: v[31:0] = {s, 31'b0};
        1: v[31:0] = {s, 8'hFF, 23'b0};
        2: v[31:0] = {s, 8'hFF, 1'b1, v[21:0]};
        3: v[31:0] = {s, 8'hFF, 1'b0, v[21:1], 1'b1};
        4: v[31:0] = {s, 8'h7F, 13'h0, v[9:0]};
        default: v[30:23] = 8'(($urandom_range(0, 254)));
      endcase
    end
    return v;
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    checkNow("R10 reset state");
    @(negedge clk);
    rst = 1'b0;

    // R1 basic predicates, single
    allPreds(0, 64'h0000_0000_3F80_0000, 64'h0000_0000_4000_0000, "R1");
    allPreds(0, 64'h0000_0000_4000_0000, 64'h0000_0000_3F80_0000, "R1");
    allPreds(0, 64'h0000_0000_4000_0000, 64'h0000_0000_4000_0000, "R1");
    // R3 upper half ignored in single mode
    allPreds(0, 64'hFFF8_0000_3F80_0000, 64'h1234_5678_3F80_0000, "R3");
    allPreds(0, 64'h7FF0_0001_4000_0000, 64'h0000_0000_3F80_0000, "R3");
    // R3 double mode
    allPreds(1, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0001, "R3");
    allPreds(1, 64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R3");
    // R4 quiet and signalling NaNs
    allPreds(0, 64'h0000_0000_7FC0_0000, 64'h0000_0000_3F80_0000, "R4");
    allPreds(0, 64'h0000_0000_3F80_0000, 64'h0000_0000_7F80_0001, "R4");
    allPreds(0, 64'h0000_0000_7F80_0001, 64'h0000_0000_7F80_0001, "R4");
    allPreds(1, 64'h7FF8_0000_0000_0000, 64'h3F80_0000_0000_0000, "R4");
    allPreds(1, 64'h7FF0_0000_0000_0001, 64'hFFF0_0000_0000_0000, "R4");
    allPreds(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
    // R6 signed zeros
    allPreds(0, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0000, "R6");
    allPreds(0, 64'h0000_0000_0000_0000, 64'h0000_0000_8000_0000, "R6");
    allPreds(1, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000, "R6");
    // R7 infinities
    allPreds(0, 64'h0000_0000_7F80_0000, 64'h0000_0000_7F7F_FFFF, "R7");
    allPreds(0, 64'h0000_0000_FF80_0000, 64'h0000_0000_FF7F_FFFF, "R7");
    allPreds(0, 64'h0000_0000_7F80_0000, 64'h0000_0000_FF80_0000, "R7");
    allPreds(1, 64'hFFF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, "R7");
    allPreds(1, 64'h7FF0_0000_0000_0000, 64'h0000_0000_0000_0001, "R7");
    // R8 mixed signs and positive ordering
    allPreds(0, 64'h0000_0000_0000_0001, 64'h0000_0000_8000_0001, "R8");
    allPreds(1, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, "R8");
    // R9 both negative
    allPreds(0, 64'h0000_0000_BF80_0000, 64'h0000_0000_C000_0000, "R9");
    allPreds(1, 64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000, "R9");
    allPreds(1, 64'hBD73_1F75_0000_0000, 64'hBD73_1F75_0000_0000, "R9");

    // R10 and R1..R9 mixed random patterns
    for (int i = 0; i < N_RANDOM; i++) begin
      bit dbl;
      logic [63:0] a, b;
      dbl = $urandom_range(0, 1) == 1;
      a = makeOp(dbl, $urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) begin
        b = a;
        if ($urandom_range(0, 1) == 1) b[dbl ? 0 : 32] = ~b[dbl ? 0 : 32];
      end else begin
        b = makeOp(dbl, $urandom_range(0, 7));
      end
      applyVec(dbl, 2'($urandom_range(0, 3)), a, b, "R10");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule